// File: doc/BRIEF.md
# MSI Event Queue Writer

This block turns incoming message-signalled interrupts into entries in a set of circular event queues that live in host memory. Every MSI carries a vector number and a 16-bit data value. A programmable routing table maps the vector to one of the queues. The block then writes a 32-bit entry at that queue's tail slot through a single-beat memory write port. That port returns a completion acknowledge. Only after the acknowledge does the block move the queue's tail forward. The queue's interrupt line rises in that same step.

Every queue holds a fixed ring of 64 word entries. The block owns the tail pointer and software owns the head pointer. Software drains entries and then writes a new head value. The interrupt line for a queue is a level: it stays high for as long as unread entries remain. When a queue has no free slot, the block holds the MSI with backpressure on the endpoint side and never drops it. Only one memory write is in flight at any time, so entries reach memory in the order the MSIs arrived.

Top module: `msi_evq_writer`

## Requirements
- R1: Each entry word carries the MSI data value in bits [15:0]. Bits [31:16] hold the vector number, zero-extended, as a controller-private tag.
- R2: An entry is written to the selected queue's base address plus four times its tail pointer. Each queue's base is programmable and takes effect from the next cycle.
- R3: A queue's 6-bit tail advances by one, modulo 64, in the cycle after `mem_ack` is sampled high with a request pending, and at no other time. While the request is unacknowledged, `mem_req`, `mem_addr` and `mem_wdata` hold steady.
- R4: `irq[q]` is high exactly when queue q's tail differs from its head. A new entry raises it in the same cycle that the advanced tail appears, never earlier.
- R5: A queue is full when tail+1 equals head, modulo 64. An MSI routed to a full queue sees `msi_ready` low and stays pending until software frees a slot; it is never lost.
- R6: At most one entry write is outstanding. `msi_ready` is low while `mem_req` is high, and the MSI handshake is `msi_valid && msi_ready`.
- R7: After reset the routing table sends vector v to queue v mod NUM_Q. Writing an entry redirects the later MSIs of that vector to the new queue.
- R8: A software head write sets that queue's head from the next cycle. This frees slots and can clear the interrupt.
- R9: `mem_ack` sampled while no request is pending has no effect on any pointer or output.
- R10: During and right after reset, all tails and heads are 0, `irq` is all low, `mem_req` is low and `msi_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_valid | input | 1 | An MSI is offered |
| msi_ready | output | 1 | The block takes the MSI this cycle |
| msi_vec | input | VEC_W | MSI vector number |
| msi_data | input | 16 | MSI data value |
| route_we | input | 1 | Write one routing-table entry |
| route_vec | input | VEC_W | Vector whose routing is written |
| route_q | input | QW | Queue assigned to that vector |
| base_we | input | 1 | Write a queue base address |
| base_sel | input | QW | Queue whose base is written |
| base_addr | input | ADDR_W | New base address |
| head_we | input | 1 | Software head-pointer write |
| head_sel | input | QW | Queue whose head is written |
| head_ptr | input | PTR_W | New head value |
| mem_req | output | 1 | Entry write request pending |
| mem_addr | output | ADDR_W | Entry byte address |
| mem_wdata | output | 32 | Entry word |
| mem_ack | input | 1 | Entry write completed in memory |
| tail_ptrs | output | NUM_Q*PTR_W | Tail pointers, queue q at bits [q*PTR_W +: PTR_W] |
| irq | output | NUM_Q | Per-queue level interrupt |

## Verification
`msi_ready` is combinational, so it is due in the same cycle as the inputs. `mem_req`, the entry address and the entry word appear one edge after the handshake. Tail and `irq` change one edge after the edge that samples `mem_ack`. Head, routing and base writes act from the next cycle. The bench drives inputs on the falling edge and samples 1 ns later. At each falling edge it steps a behavioural model by exactly one rising edge, so every compare falls in the cycle where the result is due. Explicit checks cover the stalled full queue, tail wraparound and stray acknowledges.

// File: rtl/msi_evq_pkg.sv
package msi_evq_pkg;

    // Entry write engine state
    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_BUSY = 1'b1
    } wr_state_e;

    localparam int ENTRY_W   = 32;
    localparam int PAYLOAD_W = 16;

endpackage

// File: rtl/msi_evq_route.sv
module msi_evq_route #(
    parameter  int NUM_VEC = 64,
    parameter  int NUM_Q   = 4,
    localparam int VEC_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int QW      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VEC_W-1:0] wr_vec,
    input  logic [QW-1:0]    wr_q,
    input  logic [VEC_W-1:0] rd_vec,
    output logic [QW-1:0]    rd_q
);

    logic [QW-1:0] map_q [NUM_VEC];
    logic [QW-1:0] map_d [NUM_VEC];

    always_comb begin
        map_d = map_q;
        if (wr_en) begin
            map_d[wr_vec] = wr_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VEC; i++) begin
                map_q[i] <= QW'(i % NUM_Q);
            end
        end else begin
            map_q <= map_d;
        end
    end

    assign rd_q = map_q[rd_vec];

endmodule

// File: rtl/msi_evq_ring.sv
module msi_evq_ring #(
    parameter int PTR_W  = 6,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              head_we,
    input  logic [PTR_W-1:0]  head_val,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_val,
    output logic [PTR_W-1:0]  tail,
    output logic [PTR_W-1:0]  head,
    output logic              full,
    output logic              irq,
    output logic [ADDR_W-1:0] entry_addr
);

    typedef struct packed {
        logic [PTR_W-1:0]  tail;
        logic [PTR_W-1:0]  head;
        logic [ADDR_W-1:0] base;
    } ring_t;

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (adv) begin
            ring_d.tail = ring_q.tail + PTR_W'(1);
        end
        if (head_we) begin
            ring_d.head = head_val;
        end
        if (base_we) begin
            ring_d.base = base_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign tail       = ring_q.tail;
    assign head       = ring_q.head;
    assign full       = (ring_q.tail + PTR_W'(1)) == ring_q.head;
    assign irq        = ring_q.tail != ring_q.head;
    assign entry_addr = ring_q.base + ADDR_W'({ring_q.tail, 2'b00});

endmodule

// File: rtl/msi_evq_writer.sv
module msi_evq_writer
    import msi_evq_pkg::*;
#(
    parameter  int NUM_Q   = 4,
    parameter  int NUM_VEC = 64,
    parameter  int Q_DEPTH = 64,
    parameter  int ADDR_W  = 32,
    localparam int PTR_W   = $clog2(Q_DEPTH),
    localparam int QW      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int VEC_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   msi_valid,
    output logic                   msi_ready,
    input  logic [VEC_W-1:0]       msi_vec,
    input  logic [15:0]            msi_data,
    input  logic                   route_we,
    input  logic [VEC_W-1:0]       route_vec,
    input  logic [QW-1:0]          route_q,
    input  logic                   base_we,
    input  logic [QW-1:0]          base_sel,
    input  logic [ADDR_W-1:0]      base_addr,
    input  logic                   head_we,
    input  logic [QW-1:0]          head_sel,
    input  logic [PTR_W-1:0]       head_ptr,
    output logic                   mem_req,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [31:0]            mem_wdata,
    input  logic                   mem_ack,
    output logic [NUM_Q*PTR_W-1:0] tail_ptrs,
    output logic [NUM_Q-1:0]       irq
);

    typedef struct packed {
        wr_state_e         st;
        logic [QW-1:0]     q;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
    } wr_t;

    wr_t wr_d, wr_q;

    logic [QW-1:0]          route_sel;
    logic [NUM_Q-1:0]       q_full;
    logic [NUM_Q-1:0]       q_adv;
    logic [PTR_W-1:0]       q_tail [NUM_Q];
    logic [PTR_W-1:0]       q_head [NUM_Q];
    logic [ADDR_W-1:0]      q_addr [NUM_Q];
    logic [NUM_Q*PTR_W-1:0] head_flat;

    msi_evq_route #(
        .NUM_VEC (NUM_VEC),
        .NUM_Q   (NUM_Q)
    ) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (route_we),
        .wr_vec (route_vec),
        .wr_q   (route_q),
        .rd_vec (msi_vec),
        .rd_q   (route_sel)
    );

    for (genvar g = 0; g < NUM_Q; g++) begin : g_ring
        msi_evq_ring #(
            .PTR_W  (PTR_W),
            .ADDR_W (ADDR_W)
        ) u_ring (
            .clk        (clk),
            .rst_n      (rst_n),
            .adv        (q_adv[g]),
            .head_we    (head_we && (head_sel == QW'(g))),
            .head_val   (head_ptr),
            .base_we    (base_we && (base_sel == QW'(g))),
            .base_val   (base_addr),
            .tail       (q_tail[g]),
            .head       (q_head[g]),
            .full       (q_full[g]),
            .irq        (irq[g]),
            .entry_addr (q_addr[g])
        );
        assign tail_ptrs[g*PTR_W +: PTR_W] = q_tail[g];
        assign head_flat[g*PTR_W +: PTR_W] = q_head[g];
    end

    always_comb begin
        wr_d      = wr_q;
        q_adv     = '0;
        msi_ready = (wr_q.st == WR_IDLE) && !q_full[route_sel];
        case (wr_q.st)
            WR_IDLE: begin
                if (msi_valid && msi_ready) begin
                    wr_d.st   = WR_BUSY;
                    wr_d.q    = route_sel;
                    wr_d.addr = q_addr[route_sel];
                    wr_d.data = {PAYLOAD_W'(msi_vec), msi_data};
                end
            end
            WR_BUSY: begin
                if (mem_ack) begin
                    q_adv[wr_q.q] = 1'b1;
                    wr_d.st       = WR_IDLE;
                end
            end
            default: wr_d.st = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '{st: WR_IDLE, q: '0, addr: '0, data: '0};
        end else begin
            wr_q <= wr_d;
        end
    end

    assign mem_req   = (wr_q.st == WR_BUSY);
    assign mem_addr  = wr_q.addr;
    assign mem_wdata = wr_q.data;

endmodule

// File: rtl/msi_evq_checks.sv
module msi_evq_checks #(
    parameter int NUM_Q  = 4,
    parameter int PTR_W  = 6,
    parameter int ADDR_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   msi_ready,
    input logic                   mem_req,
    input logic                   mem_ack,
    input logic [ADDR_W-1:0]      mem_addr,
    input logic [31:0]            mem_wdata,
    input logic                   head_we,
    input logic [NUM_Q*PTR_W-1:0] tail_ptrs,
    input logic [NUM_Q*PTR_W-1:0] head_flat,
    input logic [NUM_Q-1:0]       irq
);

    // R3: request and its payload hold until acknowledged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    // R6: nothing accepted while a write is outstanding
    p_single_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !msi_ready);

    // R9: an acknowledge without a request leaves all tails alone
    p_ack_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && mem_ack) |=> $stable(tail_ptrs));

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        // R3: a tail moves only after a completed write
        p_tail_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(tail_ptrs[g*PTR_W +: PTR_W]) |-> $past(mem_req && mem_ack));

        // R5: advancing never collides with head
        p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!$stable(tail_ptrs[g*PTR_W +: PTR_W]) && !$past(head_we))
            |-> (tail_ptrs[g*PTR_W +: PTR_W] != head_flat[g*PTR_W +: PTR_W]));

        // R4: interrupt rises only once the entry is confirmed and tail moved
        p_irq_after_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(irq[g]) && !$past(head_we)) |-> ($past(mem_req && mem_ack)
            && !$stable(tail_ptrs[g*PTR_W +: PTR_W])));
    end

endmodule

bind msi_evq_writer msi_evq_checks #(
    .NUM_Q  (NUM_Q),
    .PTR_W  (PTR_W),
    .ADDR_W (ADDR_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .msi_ready (msi_ready),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .head_we   (head_we),
    .tail_ptrs (tail_ptrs),
    .head_flat (head_flat),
    .irq       (irq)
);

// File: tb/test_msi_evq_writer.sv
module test_msi_evq_writer;

    localparam int NQ = 4;
    localparam int NV = 64;
    localparam int DEPTH = 64;
    localparam int AW = 32;
    localparam int PW = 6;
    localparam int QW = 2;
    localparam int VW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msi_valid = 1'b0;
    logic          msi_ready;
    logic [VW-1:0] msi_vec = '0;
    logic [15:0]   msi_data = '0;
    logic          route_we = 1'b0;
    logic [VW-1:0] route_vec = '0;
    logic [QW-1:0] route_q = '0;
    logic          base_we = 1'b0;
    logic [QW-1:0] base_sel = '0;
    logic [AW-1:0] base_addr = '0;
    logic          head_we = 1'b0;
    logic [QW-1:0] head_sel = '0;
    logic [PW-1:0] head_ptr = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic [NQ*PW-1:0] tail_ptrs;
    logic [NQ-1:0] irq;

    always #2 clk = ~clk;

    msi_evq_writer #(
        .NUM_Q   (NQ),
        .NUM_VEC (NV),
        .Q_DEPTH (DEPTH),
        .ADDR_W  (AW)
    ) i_msi_evq_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .msi_valid (msi_valid),
        .msi_ready (msi_ready),
        .msi_vec   (msi_vec),
        .msi_data  (msi_data),
        .route_we  (route_we),
        .route_vec (route_vec),
        .route_q   (route_q),
        .base_we   (base_we),
        .base_sel  (base_sel),
        .base_addr (base_addr),
        .head_we   (head_we),
        .head_sel  (head_sel),
        .head_ptr  (head_ptr),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .tail_ptrs (tail_ptrs),
        .irq       (irq)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // behavioural reference state
    int          m_tail [NQ];
    int          m_head [NQ];
    int          m_route [NV];
    logic [31:0] m_base [NQ];
    bit          m_busy;
    int          m_q;
    logic [31:0] m_addr;
    logic [31:0] m_data;
    int          m_wait;
    int          ack_lat = 0;
    bit          stray = 0;
    bit          took;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    function automatic bit m_full(input int q);
        return ((m_tail[q] + 1) % DEPTH) == m_head[q];
    endfunction

    function automatic logic [NQ*PW-1:0] m_tails();
        logic [NQ*PW-1:0] t;
        for (int q = 0; q < NQ; q++) t[q*PW +: PW] = PW'(m_tail[q]);
        return t;
    endfunction

    // one clock: entered at a falling edge with inputs set, leaves at the next
    task automatic cycle();
        bit er;
        logic [NQ-1:0] ei;
        mem_ack = (m_busy && (m_wait >= ack_lat)) || (!m_busy && stray);
        #1;
        er = !m_busy && !m_full(m_route[msi_vec]);
        check(msi_ready === er, m_busy ? "R6 ready" : "R5 ready", 64'(msi_ready), 64'(er));
        check(mem_req === m_busy, "R6 req", 64'(mem_req), 64'(m_busy));
        if (m_busy) begin
            check(mem_addr === m_addr, "R2 addr", 64'(mem_addr), 64'(m_addr));
            check(mem_wdata === m_data, "R1 entry", 64'(mem_wdata), 64'(m_data));
        end
        check(tail_ptrs === m_tails(), "R3 tails", 64'(tail_ptrs), 64'(m_tails()));
        for (int q = 0; q < NQ; q++) ei[q] = (m_tail[q] != m_head[q]);
        check(irq === ei, "R4 irq", 64'(irq), 64'(ei));
        took = 0;
        if (m_busy) begin
            if (mem_ack) begin
                m_tail[m_q] = (m_tail[m_q] + 1) % DEPTH;
                m_busy = 0;
            end else begin
                m_wait++;
            end
        end else if (msi_valid && er) begin
            m_busy = 1;
            m_q    = m_route[msi_vec];
            m_addr = m_base[m_q] + 32'(m_tail[m_q] * 4);
            m_data = {16'(msi_vec), msi_data};
            m_wait = 0;
            took   = 1;
        end
        if (route_we) m_route[route_vec] = int'(route_q);
        if (base_we)  m_base[base_sel] = base_addr;
        if (head_we)  m_head[head_sel] = int'(head_ptr);
        @(negedge clk);
    endtask

    task automatic post(input int v, input logic [15:0] d);
        msi_valid = 1'b1;
        msi_vec   = VW'(v);
        msi_data  = d;
        do cycle(); while (!took);
        msi_valid = 1'b0;
    endtask

    task automatic drain();
        while (m_busy) cycle();
        cycle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int q = 0; q < NQ; q++) begin
            m_tail[q] = 0;
            m_head[q] = 0;
            m_base[q] = '0;
        end
        for (int v = 0; v < NV; v++) m_route[v] = v % NQ;
        m_busy = 0;
        m_wait = 0;

        // R10: reset state, both during and after reset
        repeat (3) @(negedge clk);
        #1;
        check(mem_req === 1'b0, "R10 req in reset", 64'(mem_req), 64'd0);
        check(irq === '0, "R10 irq in reset", 64'(irq), 64'd0);
        check(tail_ptrs === '0, "R10 tails in reset", 64'(tail_ptrs), 64'd0);
        check(msi_ready === 1'b1, "R10 ready in reset", 64'(msi_ready), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        cycle();

        // R1/R4: basic post, default routing vector 3 -> queue 3
        post(3, 16'hA5A5);
        drain();
        check(irq[3] === 1'b1, "R4 irq after post", 64'(irq), 64'h8);

        // R2: programmed base for queue 1
        base_we = 1; base_sel = 2'd1; base_addr = 32'h1000_0000;
        cycle();
        base_we = 0;
        post(1, 16'h1234);
        drain();
        post(1, 16'h5678);
        drain();

        // R7: redirect vector 5 from queue 1 to queue 2
        route_we = 1; route_vec = 6'd5; route_q = 2'd2;
        cycle();
        route_we = 0;
        post(5, 16'hBEEF);
        drain();
        check(tail_ptrs[2*PW +: PW] === 6'd1, "R7 rerouted tail", 64'(tail_ptrs[2*PW +: PW]), 64'd1);
        check(tail_ptrs[1*PW +: PW] === 6'd2, "R7 old queue untouched", 64'(tail_ptrs[1*PW +: PW]), 64'd2);

        // R9: stray acknowledges with no request
        stray = 1;
        repeat (4) cycle();
        stray = 0;
        check(tail_ptrs === m_tails(), "R9 stray ack", 64'(tail_ptrs), 64'(m_tails()));

        // R3: slow acknowledge, tail waits
        ack_lat = 4;
        post(2, 16'h0F0F);
        repeat (2) cycle();
        check(tail_ptrs[2*PW +: PW] === 6'd1, "R3 tail held before ack", 64'(tail_ptrs[2*PW +: PW]), 64'd1);
        drain();
        check(tail_ptrs[2*PW +: PW] === 6'd2, "R3 tail after ack", 64'(tail_ptrs[2*PW +: PW]), 64'd2);
        ack_lat = 0;

        // R8: software head catches up, interrupt clears
        head_we = 1; head_sel = 2'd3; head_ptr = 6'd1;
        cycle();
        head_we = 0;
        cycle();
        check(irq[3] === 1'b0, "R8 irq cleared", 64'(irq[3]), 64'd0);

        // R5: fill queue 0 to 63 entries, then stall
        for (int i = 0; i < 63; i++) post(0, 16'(i));
        drain();
        msi_valid = 1; msi_vec = 6'd0; msi_data = 16'hCAFE;
        for (int i = 0; i < 8; i++) begin
            cycle();
            check(took == 0, "R5 held while full", 64'(took), 64'd0);
        end
        check(tail_ptrs[PW-1:0] === 6'd63, "R5 tail at full", 64'(tail_ptrs[PW-1:0]), 64'd63);
        head_we = 1; head_sel = 2'd0; head_ptr = 6'd10;
        cycle();
        head_we = 0;
        while (!took) cycle();
        msi_valid = 0;
        // R3: wraparound of tail and address
        for (int i = 0; i < 4; i++) post(0, 16'h7000 + 16'(i));
        drain();
        check(tail_ptrs[PW-1:0] === 6'd4, "R3 tail wrapped", 64'(tail_ptrs[PW-1:0]), 64'd4);

        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            if (took) msi_valid = 0;
            if (!msi_valid && ($urandom % 3 == 0)) begin
                msi_valid = 1;
                msi_vec   = VW'($urandom % NV);
                msi_data  = 16'($urandom);
            end
            if (!m_busy) ack_lat = $urandom % 4;
            route_we = ($urandom % 40 == 0);
            route_vec = VW'($urandom % NV);
            route_q   = QW'($urandom % NQ);
            base_we   = ($urandom % 60 == 0);
            base_sel  = QW'($urandom % NQ);
            base_addr = {$urandom, 2'b00};
            head_we   = ($urandom % 5 == 0);
            head_sel  = QW'($urandom % NQ);
            head_ptr  = PW'(m_tail[head_sel]);
            cycle();
            route_we = 0; base_we = 0; head_we = 0;
        end
        msi_valid = 0;
        drain();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule